// File: doc/BRIEF.md
# Huffman code-length search sequencer

This block works out the length of a canonical Huffman code that arrives one bit at a time. It holds two banks of first-level tables, one for AC codes and one for DC codes. Each bank has one row per code length from 2 to 9, and each row stores the largest code value of that length and a base offset. After a restart pulse the block takes in code bits and steps a one-hot marker through the rows in increasing length order. The marker selects a row directly, so no counter and decoder sit in front of the table. In each step the bits gathered so far are compared with that row's maximum code. On the first length where the code is not above the maximum, the block presents the length and a second-level table address, which is the row's base plus the code value.

The code bits enter on a valid/ready stream. A bit moves only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only while a search is under way and the current length has neither matched nor run out. The result leaves on a valid/ready stream. `out_valid` stays high, with length and address held steady, until `out_ready` is seen high. After that handshake the block idles until the next restart.

The tables are loaded during initialisation through a plain write port that addresses rows by an explicit index. A single bank select chooses DC (1) or AC (0) for both writes and searches.

Top module: `hcl_seeker`

## Requirements
- R1: While `rst` is high and after it falls, the block idles with `out_valid`=0, `in_ready`=0 and `err`=0 until a restart. A synchronous reset also clears every table row to zero.
- R2: In the cycle after `restart` is high, the block is searching. `in_ready`=1, the gathered code is empty and the marker stands before length 2.
- R3: Bits arrive MSB first. The code resolves at the smallest length L in the range 2..9 whose first L bits, read as an unsigned number, are at most the maximum code of row L-2 in the selected bank. `out_len` = L, and exactly L bits are consumed.
- R4: `out_addr` is the 10-bit unsigned sum of the matched row's 6-bit base and the L-bit code value.
- R5: `bank_dc`=1 selects the DC bank and `bank_dc`=0 the AC bank, for both writes and searches. A write to one bank leaves the other bank unchanged.
- R6: When `wr_en` is high at a clock edge, `wr_max` and `wr_base` are stored into row `wr_row` of the selected bank. Row r holds length r+2. A later write to the same row replaces the earlier values.
- R7: A single gathered bit never resolves a code, whatever its value. The first comparison is made only once 2 bits are in.
- R8: If length 9 does not match, `err` rises and `in_ready` falls. `out_valid` then stays low until the next restart.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_len` and `out_addr` hold. In the cycle after a handshake, `out_valid`=0 and `in_ready`=0.
- R10: Bits offered while `in_ready` is low (idle, result pending or error) are not consumed. They produce no result and do not clear `err`.
- R11: A restart overrides any state. It drops a pending result and clears `err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_dc | input | 1 | Bank select: 1 DC, 0 AC (writes and searches) |
| wr_en | input | 1 | Table write strobe |
| wr_row | input | 3 | Row index for a write (row r = length r+2) |
| wr_max | input | 9 | Maximum code value to store |
| wr_base | input | 6 | Base offset to store |
| restart | input | 1 | Starts a new code search |
| in_valid | input | 1 | Code bit valid |
| in_ready | output | 1 | Block accepts a code bit |
| in_bit | input | 1 | Code bit, MSB first |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 4 | Resolved code length (2..9) |
| out_addr | output | 10 | Second-level table address |
| err | output | 1 | No length matched up to 9 |

## Verification
Codes of every length from 2 to 9 are sent into both banks from a table of vectors. Codes that fail at several shorter lengths before matching tell a walk in order apart from a wrong row select. The same leading bits give different lengths in the AC and DC banks, which separates the banks. A single zero bit held before a second bit exposes any comparison made at length 1. An all-ones 9-bit code drives the miss path, and bits offered afterwards must be ignored. A held result, a restart over a pending result, and a rewritten row round out the coverage of the handshake and the write port.

// File: rtl/hcl_pkg.sv
package hcl_pkg;
  localparam int DEF_ROWS    = 8;
  localparam int DEF_MIN_LEN = 2;
  localparam int DEF_BASE_W  = 6;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SEARCH = 2'd1,
    S_DONE   = 2'd2,
    S_FAULT  = 2'd3
  } seek_state_e;
endpackage

// File: rtl/hcl_table_bank.sv
module hcl_table_bank #(
  parameter int ROWS   = 8,
  parameter int CODE_W = 9,
  parameter int BASE_W = 6,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [CODE_W-1:0] wmax,
  input  logic [BASE_W-1:0] wbase,
  input  logic [ROWS-1:0]   rsel,
  output logic [CODE_W-1:0] rmax,
  output logic [BASE_W-1:0] rbase
);
  logic [CODE_W-1:0] max_q  [ROWS];
  logic [BASE_W-1:0] base_q [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) begin
        max_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else if (we) begin
      max_q[wrow]  <= wmax;
      base_q[wrow] <= wbase;
    end
  end

  // one-hot row select drives an AND-OR read; no row selected reads as zero
  always_comb begin
    rmax  = '0;
    rbase = '0;
    for (int i = 0; i < ROWS; i++) begin
      rmax  = rmax  | (max_q[i]  & {CODE_W{rsel[i]}});
      rbase = rbase | (base_q[i] & {BASE_W{rsel[i]}});
    end
  end
endmodule

// File: rtl/hcl_len_shifter.sv
module hcl_len_shifter #(
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            step,
  output logic [ROWS-1:0] rows
);
  // stage 0 stands for length MIN_LEN-1 and owns no table row
  logic [ROWS:0] chain_q;
  logic          feed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      feed_q  <= 1'b0;
    end else if (clear) begin
      chain_q <= '0;
      feed_q  <= 1'b1;
    end else if (step) begin
      chain_q <= {chain_q[ROWS-1:0], feed_q};
      feed_q  <= 1'b0;
    end
  end

  assign rows = chain_q[ROWS:1];
endmodule

// File: rtl/hcl_matcher.sv
module hcl_matcher #(
  parameter int ROWS    = 8,
  parameter int MIN_LEN = 2,
  parameter int CODE_W  = 9,
  parameter int BASE_W  = 6,
  parameter int LEN_W   = 4,
  parameter int ADDR_W  = 10
) (
  input  logic [ROWS-1:0]   rows,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] rmax,
  input  logic [BASE_W-1:0] rbase,
  output logic              hit,
  output logic              miss,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] addr
);
  assign hit  = (|rows) && (code <= rmax);
  assign miss = rows[ROWS-1] && !(code <= rmax);
  assign addr = ADDR_W'(rbase) + ADDR_W'(code);

  always_comb begin
    len = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (rows[i]) len = len | LEN_W'(i + MIN_LEN);
    end
  end
endmodule

// File: rtl/hcl_seeker.sv
module hcl_seeker #(
  parameter int ROWS    = hcl_pkg::DEF_ROWS,
  parameter int MIN_LEN = hcl_pkg::DEF_MIN_LEN,
  parameter int BASE_W  = hcl_pkg::DEF_BASE_W,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int CODE_W = MIN_LEN + ROWS - 1,
  localparam int LEN_W  = $clog2(CODE_W + 1),
  localparam int ADDR_W = ((CODE_W > BASE_W) ? CODE_W : BASE_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_dc,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [CODE_W-1:0] wr_max,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic [ADDR_W-1:0] out_addr,
  output logic              err
);
  import hcl_pkg::*;

  seek_state_e       state_q;
  logic [CODE_W-1:0] code_q;
  logic [ROWS-1:0]   row_sel;
  logic [CODE_W-1:0] bank_max  [2];
  logic [BASE_W-1:0] bank_base [2];
  logic [CODE_W-1:0] sel_max;
  logic [BASE_W-1:0] sel_base;
  logic              hit_c, miss_c, hit, miss, accept;
  logic [LEN_W-1:0]  len_c;
  logic [ADDR_W-1:0] addr_c;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    hcl_table_bank #(.ROWS(ROWS), .CODE_W(CODE_W), .BASE_W(BASE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && (bank_dc == b[0])),
      .wrow  (wr_row),
      .wmax  (wr_max),
      .wbase (wr_base),
      .rsel  (row_sel),
      .rmax  (bank_max[b]),
      .rbase (bank_base[b])
    );
  end

  assign sel_max  = bank_dc ? bank_max[1]  : bank_max[0];
  assign sel_base = bank_dc ? bank_base[1] : bank_base[0];

  hcl_len_shifter #(.ROWS(ROWS)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clear (restart),
    .step  (accept && !restart),
    .rows  (row_sel)
  );

  hcl_matcher #(
    .ROWS(ROWS), .MIN_LEN(MIN_LEN), .CODE_W(CODE_W),
    .BASE_W(BASE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_match (
    .rows  (row_sel),
    .code  (code_q),
    .rmax  (sel_max),
    .rbase (sel_base),
    .hit   (hit_c),
    .miss  (miss_c),
    .len   (len_c),
    .addr  (addr_c)
  );

  assign hit      = (state_q == S_SEARCH) && hit_c;
  assign miss     = (state_q == S_SEARCH) && miss_c;
  assign in_ready = (state_q == S_SEARCH) && !hit_c && !miss_c;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      code_q    <= '0;
      out_valid <= 1'b0;
      out_len   <= '0;
      out_addr  <= '0;
      err       <= 1'b0;
    end else if (restart) begin
      state_q   <= S_SEARCH;
      code_q    <= '0;
      out_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      unique case (state_q)
        S_SEARCH: begin
          if (accept) code_q <= {code_q[CODE_W-2:0], in_bit};
          if (hit) begin
            out_valid <= 1'b1;
            out_len   <= len_c;
            out_addr  <= addr_c;
            state_q   <= S_DONE;
          end else if (miss) begin
            err     <= 1'b1;
            state_q <= S_FAULT;
          end
        end
        S_DONE: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state_q   <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hcl_seeker_chk.sv
module hcl_seeker_chk #(
  parameter int ROWS   = 8,
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              restart,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LEN_W-1:0]  out_len,
  input logic [ADDR_W-1:0] out_addr,
  input logic              err,
  input logic [ROWS-1:0]   row_sel
);
  p_onehot_rows_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));

  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 2 && out_len <= 9));

  p_restart_arms_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> in_ready);

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!in_ready && !out_valid));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !restart) |=>
      (out_valid && $stable(out_len) && $stable(out_addr)));

  p_after_handshake_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !restart) |=> (!out_valid && !in_ready));

  p_no_take_pending_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_restart_clears_r11: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out_valid && !err));
endmodule

bind hcl_seeker hcl_seeker_chk #(.ROWS(ROWS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .restart   (restart),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_len   (out_len),
  .out_addr  (out_addr),
  .err       (err),
  .row_sel   (row_sel)
);

// File: tb/tb_hcl_seeker.sv
module tb_hcl_seeker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_dc = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_row = '0;
  logic [8:0] wr_max = '0;
  logic [5:0] wr_base = '0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, err;
  logic [3:0] out_len;
  logic [9:0] out_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hcl_seeker dut (
    .clk(clk), .rst(rst), .bank_dc(bank_dc), .wr_en(wr_en), .wr_row(wr_row),
    .wr_max(wr_max), .wr_base(wr_base), .restart(restart), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_len(out_len), .out_addr(out_addr), .err(err)
  );

  typedef struct packed {
    logic       dc;
    logic [8:0] pat;
    logic [3:0] len;
    logic [9:0] addr;
  } vec_t;

  // AC max: 0,4,11,26,56,118,240,504  base: 1,4,9,12,20,30,40,50
  // DC max: 1,5,12,26,54,110,222,447  base: 2,5,7,10,11,13,15,17
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 9'b000000000, 4'd2, 10'd1},
    '{1'b0, 9'b011000000, 4'd3, 10'd7},
    '{1'b0, 9'b101100000, 4'd4, 10'd20},
    '{1'b0, 9'b110000000, 4'd5, 10'd36},
    '{1'b0, 9'b111000000, 4'd6, 10'd76},
    '{1'b0, 9'b111011000, 4'd7, 10'd148},
    '{1'b0, 9'b111100000, 4'd8, 10'd280},
    '{1'b0, 9'b111111000, 4'd9, 10'd554},
    '{1'b0, 9'b010000000, 4'd3, 10'd6},
    '{1'b1, 9'b010000000, 4'd2, 10'd3},
    '{1'b1, 9'b101000000, 4'd3, 10'd10},
    '{1'b1, 9'b110000000, 4'd4, 10'd19},
    '{1'b1, 9'b110100000, 4'd5, 10'd36},
    '{1'b1, 9'b110111110, 4'd9, 10'd463}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_row(input logic dc, input int row, input int mx, input int bs);
    bank_dc = dc; wr_row = 3'(row); wr_max = 9'(mx); wr_base = 6'(bs); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // sends pattern MSB first while in_ready; returns at a negedge with result or error
  task automatic send_code(input logic dc, input logic [8:0] pat, output int used,
                           output logic got_v, output logic got_e);
    bank_dc = dc;
    do_restart();
    used = 0; got_v = 1'b0; got_e = 1'b0;
    for (int k = 0; k < 24; k++) begin
      if (out_valid) begin got_v = 1'b1; break; end
      if (err) begin got_e = 1'b1; break; end
      if (in_ready && used < 9) begin
        in_valid = 1'b1; in_bit = pat[8-used]; used++;
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic handshake();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int   used;
    logic gv, ge;
    localparam int AC_MAX [8] = '{0, 4, 11, 26, 56, 118, 240, 504};
    localparam int AC_BAS [8] = '{1, 4, 9, 12, 20, 30, 40, 50};
    localparam int DC_MAX [8] = '{1, 5, 12, 26, 54, 110, 222, 447};
    localparam int DC_BAS [8] = '{2, 5, 7, 10, 11, 13, 15, 17};

    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 0);
    chk("R1 err after reset", int'(err), 0);

    for (int r = 0; r < 8; r++) write_row(1'b0, r, AC_MAX[r], AC_BAS[r]);
    for (int r = 0; r < 8; r++) write_row(1'b1, r, DC_MAX[r], DC_BAS[r]);

    do_restart();
    chk("R2 in_ready after restart", int'(in_ready), 1);
    chk("R2 no result after restart", int'(out_valid), 0);

    // R3 R4 R5 R6: vector walk over both banks
    for (int v = 0; v < NV; v++) begin
      send_code(VECS[v].dc, VECS[v].pat, used, gv, ge);
      chk($sformatf("R3 vec%0d result seen", v), int'(gv), 1);
      chk($sformatf("R3 vec%0d length", v), int'(out_len), int'(VECS[v].len));
      chk($sformatf("R3 vec%0d bits consumed", v), used, int'(VECS[v].len));
      chk($sformatf("R4 R5 vec%0d address", v), int'(out_addr), int'(VECS[v].addr));
      handshake();
    end

    // R7: one zero bit (would fit DC length-2 max of 1) must not resolve
    bank_dc = 1'b1;
    do_restart();
    in_valid = 1'b1; in_bit = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 no result on one bit", int'(out_valid), 0);
    chk("R7 still searching", int'(in_ready), 1);
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 resolves at two bits", int'(out_valid), 1);
    chk("R7 length", int'(out_len), 2);
    chk("R7 address", int'(out_addr), 3);

    // R9: hold while not ready, then handshake
    repeat (3) @(negedge clk);
    chk("R9 held valid", int'(out_valid), 1);
    chk("R9 held length", int'(out_len), 2);
    chk("R9 held address", int'(out_addr), 3);
    handshake();
    chk("R9 valid drops after handshake", int'(out_valid), 0);
    chk("R9 ready low after handshake", int'(in_ready), 0);

    // R10: bits offered while idle are ignored
    in_valid = 1'b1; in_bit = 1'b0;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    chk("R10 no result from idle bits", int'(out_valid), 0);
    chk("R10 ready stays low", int'(in_ready), 0);

    // R8: all-ones 9-bit AC code misses
    send_code(1'b0, 9'b111111111, used, gv, ge);
    chk("R8 err raised", int'(ge), 1);
    chk("R8 nine bits consumed", used, 9);
    chk("R8 ready low on err", int'(in_ready), 0);
    chk("R8 no result on err", int'(out_valid), 0);
    in_valid = 1'b1; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R10 err kept with bits offered", int'(err), 1);
    chk("R10 no result with bits offered", int'(out_valid), 0);
    do_restart();
    chk("R11 restart clears err", int'(err), 0);

    // R11: restart drops a pending result
    send_code(1'b0, 9'b000000000, used, gv, ge);
    chk("R11 pending result present", int'(out_valid), 1);
    do_restart();
    chk("R11 restart drops result", int'(out_valid), 0);
    chk("R11 restart searching", int'(in_ready), 1);

    // R6 R5: rewrite AC row 0, DC bank unchanged
    write_row(1'b0, 0, 3, 63);
    send_code(1'b0, 9'b100000000, used, gv, ge);
    chk("R6 rewritten row length", int'(out_len), 2);
    chk("R6 rewritten row address", int'(out_addr), 65);
    handshake();
    send_code(1'b1, 9'b010000000, used, gv, ge);
    chk("R5 DC row untouched length", int'(out_len), 2);
    chk("R5 DC row untouched address", int'(out_addr), 3);
    handshake();

    // R1: reset clears tables (AC row 0 back to max 0, base 0)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send_code(1'b0, 9'b000000000, used, gv, ge);
    chk("R1 cleared table length", int'(out_len), 2);
    chk("R1 cleared table address", int'(out_addr), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule